// File: doc/BRIEF.md
# Charging Status Indicator Sequencer

This block turns the operating state of a wireless charging transmitter into visible and audible signals. It drives a green LED, a red LED and a buzzer pin. Every interval comes from a quarter-millisecond tick that the block derives from its clock through a run-time prescale value. Four quarter ticks make one millisecond. The buzzer tone is a square wave that flips on every quarter tick, which gives 2 kHz.

The state code selects one of several patterns:
- a steady standby look, where both LEDs are lit or both are dark, chosen by an option pin that is captured once after reset;
- a slow green blink during power transfer;
- steady green when charging is complete;
- steady red on a fault;
- a fast red blink on a foreign-object warning;
- an alarm cadence on a foreign-object fault.

Entering power transfer also sounds a short chime. The alarm cadence repeats a tone burst and a gap for a long section, then stays silent for another long section, and cycles like that while the fault lasts. The red LED follows the bursts throughout, including the silent section. Every change of state code restarts all pattern timing from its beginning.

Top module: `charge_status_ind`

## Requirements
- R1: In standby (code 0) both LEDs equal the `standbyOpt` value captured on the first clock after reset; later changes of `standbyOpt` have no effect until the next reset.
- R2: In power transfer (code 1) green is lit for SLOW_MS ms and then dark for SLOW_MS ms, repeating from entry, and red is dark.
- R3: At charge complete (code 2) green is steadily lit, red is dark and the buzzer is silent.
- R4: Fault codes 3, 6 and 7 give green dark and red steadily lit, with a silent buzzer.
- R5: In a foreign-object warning (code 4) red is lit for FAST_MS ms and dark for FAST_MS ms, repeating, and green is dark.
- R6: A silent buzzer is held low. A sounding buzzer changes level on every quarter-ms tick and at no other time.
- R7: Entering power transfer sounds a tone for the first CHIME_MS ms; after that the buzzer is silent for as long as the state stays in power transfer.
- R8: In a foreign-object fault (code 5) red is lit for TONE_MS ms and dark for GAP_MS ms, repeating, and green is dark. The buzzer sounds only while red is lit.
- R9: In code 5 the bursts sound during the first ALARM_MS ms of each ALARM_MS+QUIET_MS ms cycle and are silent for the rest. The red pattern continues unchanged through the silent part, and the cycle repeats.
- R10: Leaving code 5 silences the buzzer at once. A later entry into code 5 starts again with a sounding burst at the start of the tone section.
- R11: A quarter-ms tick occurs once every `tickDiv`+1 clocks, counted afresh from each state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| stateCode | input | 3 | Operating state: 0 standby, 1 transfer, 2 complete, 3/6/7 fault, 4 foreign-object warning, 5 foreign-object fault |
| standbyOpt | input | 1 | Standby LED option, captured once after reset (1 = both lit) |
| tickDiv | input | DIV_W | Clocks per quarter-ms tick, minus one |
| greenLed | output | 1 | Green LED level, 1 = lit |
| redLed | output | 1 | Red LED level, 1 = lit |
| buzzer | output | 1 | Buzzer drive, square wave while sounding |

## Verification
Two functions can act in the same cycle. A change of state code clears the tone generator, and at that moment the alarm burst or the chime may be driving the buzzer. The bench leaves the foreign-object fault in the middle of a sounding burst. It then judges over a short sample window that the buzzer sits low and the new LED pattern is showing. It also re-enters the fault, where the red LED edge and the first tone edge coincide, and judges that red is lit and the buzzer flips once every two clocks.

// File: rtl/chg_ind_pkg.sv
package chg_ind_pkg;

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_XFER  = 3'd1;
  localparam logic [2:0] ST_DONE  = 3'd2;
  localparam logic [2:0] ST_FAULT = 3'd3;
  localparam logic [2:0] ST_WARN  = 3'd4;
  localparam logic [2:0] ST_ALARM = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic clr;
    logic toneEn;
    logic greenOn;
    logic redOn;
  } seqStrobe_t;

endpackage

// File: rtl/ind_tick_dp.sv
module ind_tick_dp
  import chg_ind_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tickDiv,
  input  seqStrobe_t       strb,
  output logic             msTick,
  output logic             greenLed,
  output logic             redLed,
  output logic             buzzer
);

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       qPh;
  logic             qTick;
  logic             toneSq;
  logic             greenQ;
  logic             redQ;

  assign qTick  = (divCnt == tickDiv);
  assign msTick = qTick && (qPh == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      qPh    <= '0;
      toneSq <= 1'b0;
      greenQ <= 1'b0;
      redQ   <= 1'b0;
    end else begin
      if (strb.clr || qTick) divCnt <= '0;
      else                   divCnt <= divCnt + DIV_W'(1);

      if (strb.clr)   qPh <= '0;
      else if (qTick) qPh <= qPh + 2'd1;

      if (strb.clr || !strb.toneEn) toneSq <= 1'b0;
      else if (qTick)               toneSq <= ~toneSq;

      greenQ <= strb.greenOn;
      redQ   <= strb.redOn;
    end
  end

  assign greenLed = greenQ;
  assign redLed   = redQ;
  assign buzzer   = toneSq;

  // R11: with a nonzero divider two ticks never fall on adjacent clocks
  assert_tick_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (qTick && tickDiv != '0) |=> (!qTick || tickDiv == '0));

  // R6: a sounding buzzer only moves on a quarter tick
  assert_buzz_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!qTick && !strb.clr && strb.toneEn) |=> $stable(toneSq));

endmodule

// File: rtl/ind_seq_ctrl.sv
module ind_seq_ctrl
  import chg_ind_pkg::*;
#(
  parameter int SLOW_MS  = 1000,
  parameter int FAST_MS  = 250,
  parameter int CHIME_MS = 400,
  parameter int TONE_MS  = 400,
  parameter int GAP_MS   = 800,
  parameter int ALARM_MS = 30000,
  parameter int QUIET_MS = 30000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] stateCode,
  input  logic       standbyOpt,
  input  logic       msTick,
  output seqStrobe_t strb
);

  localparam int EW = $clog2(ALARM_MS + QUIET_MS + CHIME_MS + 1);
  localparam int BW = $clog2(2*SLOW_MS + 2*FAST_MS + TONE_MS + GAP_MS + 1);

  localparam logic [BW-1:0] SLOW_LAST  = BW'(2*SLOW_MS - 1);
  localparam logic [BW-1:0] FAST_LAST  = BW'(2*FAST_MS - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(TONE_MS + GAP_MS - 1);
  localparam logic [BW-1:0] SLOW_ON    = BW'(SLOW_MS);
  localparam logic [BW-1:0] FAST_ON    = BW'(FAST_MS);
  localparam logic [BW-1:0] TONE_ON    = BW'(TONE_MS);
  localparam logic [EW-1:0] CHIME_LEN  = EW'(CHIME_MS);
  localparam logic [EW-1:0] ALARM_LEN  = EW'(ALARM_MS);
  localparam logic [EW-1:0] CYC_LAST   = EW'(ALARM_MS + QUIET_MS - 1);

  logic [2:0]    stateQ;
  logic          optQ;
  logic          optTaken;
  logic [EW-1:0] eCnt;     // ms since entry (wraps in alarm cadence)
  logic [BW-1:0] bCnt;     // ms within current blink period
  logic [BW-1:0] bLast;
  logic [BW-1:0] bOnLim;
  logic          bLit;
  logic          chg;

  assign chg = (stateCode != stateQ);

  always_comb begin
    case (stateQ)
      ST_WARN:  begin bLast = FAST_LAST;  bOnLim = FAST_ON; end
      ST_ALARM: begin bLast = BURST_LAST; bOnLim = TONE_ON; end
      default:  begin bLast = SLOW_LAST;  bOnLim = SLOW_ON; end
    endcase
  end

  assign bLit = (bCnt < bOnLim);

  always_comb begin
    strb.clr     = chg;
    strb.toneEn  = 1'b0;
    strb.greenOn = 1'b0;
    strb.redOn   = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        strb.greenOn = optQ;
        strb.redOn   = optQ;
      end
      ST_XFER: begin
        strb.greenOn = bLit;
        strb.toneEn  = (eCnt < CHIME_LEN);
      end
      ST_DONE:  strb.greenOn = 1'b1;
      ST_WARN:  strb.redOn   = bLit;
      ST_ALARM: begin
        strb.redOn  = bLit;
        strb.toneEn = bLit && (eCnt < ALARM_LEN);
      end
      default:  strb.redOn = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      optQ     <= 1'b0;
      optTaken <= 1'b0;
      eCnt     <= '0;
      bCnt     <= '0;
    end else begin
      if (!optTaken) begin
        optQ     <= standbyOpt;
        optTaken <= 1'b1;
      end
      if (chg) begin
        stateQ <= stateCode;
        eCnt   <= '0;
        bCnt   <= '0;
      end else if (msTick) begin
        bCnt <= (bCnt == bLast) ? '0 : bCnt + BW'(1);
        if (stateQ == ST_ALARM)
          eCnt <= (eCnt == CYC_LAST) ? '0 : eCnt + EW'(1);
        else if (eCnt != CHIME_LEN)
          eCnt <= eCnt + EW'(1);
      end
    end
  end

  // R1: the captured option never moves after capture
  assert_opt_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (optTaken && $past(optTaken)) |-> $stable(optQ));

  // R7: chime ends after its last millisecond
  assert_chime_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!chg && stateQ == ST_XFER && msTick && eCnt == CHIME_LEN - EW'(1)) |=> !strb.toneEn);

  // R9: silent section of the alarm cycle
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ALARM && eCnt >= ALARM_LEN) |-> !strb.toneEn);

  // R8: green stays dark in the foreign-object fault
  assert_green_dark_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ALARM) |-> !strb.greenOn);

  // R10: leaving the alarm for a non-transfer state silences the tone
  assert_leave_R10: assert property (@(posedge clk) disable iff (!rstN)
    (chg && stateQ == ST_ALARM && stateCode != ST_XFER) |=> !strb.toneEn);

endmodule

// File: rtl/charge_status_ind.sv
module charge_status_ind
  import chg_ind_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SLOW_MS  = 1000,
  parameter int FAST_MS  = 250,
  parameter int CHIME_MS = 400,
  parameter int TONE_MS  = 400,
  parameter int GAP_MS   = 800,
  parameter int ALARM_MS = 30000,
  parameter int QUIET_MS = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       stateCode,
  input  logic             standbyOpt,
  input  logic [DIV_W-1:0] tickDiv,
  output logic             greenLed,
  output logic             redLed,
  output logic             buzzer
);

  seqStrobe_t strb;
  logic       msTick;

  ind_seq_ctrl #(
    .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS), .CHIME_MS(CHIME_MS),
    .TONE_MS(TONE_MS), .GAP_MS(GAP_MS), .ALARM_MS(ALARM_MS), .QUIET_MS(QUIET_MS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stateCode(stateCode), .standbyOpt(standbyOpt),
    .msTick(msTick), .strb(strb)
  );

  ind_tick_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickDiv(tickDiv), .strb(strb), .msTick(msTick),
    .greenLed(greenLed), .redLed(redLed), .buzzer(buzzer)
  );

  // R8: a high buzzer in a settled foreign-object fault always has red lit
  assert_red_with_tone_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == ST_ALARM && $past(stateCode) == ST_ALARM &&
     $past(stateCode, 2) == ST_ALARM && buzzer) |-> redLed);

endmodule

// File: tb/tb_charge_status_ind.sv
module tb_charge_status_ind;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  stateCode;
  logic        standbyOpt;
  logic [15:0] tickDiv;
  logic        greenLed, redLed, buzzer;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int t0 = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    g;
    bit    r;
    bit    tone;
    string tag;
  } exp_t;
  exp_t q[$];

  // one ms = 4 quarter ticks x 2 clocks = 8 clocks with tickDiv = 1
  charge_status_ind #(
    .DIV_W(16), .SLOW_MS(4), .FAST_MS(2), .CHIME_MS(3), .TONE_MS(3),
    .GAP_MS(5), .ALARM_MS(24), .QUIET_MS(16)
  ) dut (
    .clk(clk), .rstN(rstN), .stateCode(stateCode), .standbyOpt(standbyOpt),
    .tickDiv(tickDiv), .greenLed(greenLed), .redLed(redLed), .buzzer(buzzer)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic enter(logic [2:0] code);
    @(negedge clk);
    stateCode = code;
    t0 = cyc + 1;
  endtask

  task automatic expectAt(int rel, bit g, bit r, bit tone, string tag);
    exp_t e;
    e.at = t0 + rel; e.g = g; e.r = r; e.tone = tone; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic waitRel(int rel);
    while (cyc < t0 + rel) @(negedge clk);
  endtask

  // monitor: pops expectations and judges LEDs plus tone activity over 5 samples
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && cyc >= q[0].at) begin
        exp_t e;
        bit gS, rS, prev, anyHi, ok;
        int tg;
        e = q.pop_front();
        gS = greenLed; rS = redLed; prev = buzzer; anyHi = buzzer; tg = 0;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          if (buzzer != prev) tg++;
          prev = buzzer;
          anyHi = anyHi | buzzer;
        end
        ok = (gS == e.g) && (rS == e.r) &&
             (e.tone ? (tg == 2) : (tg == 0 && !anyHi));
        check(ok, e.tag,
              $sformatf("g=%0d r=%0d toggles=%0d hi=%0d", gS, rS, tg, anyHi),
              $sformatf("g=%0d r=%0d tone=%0d", e.g, e.r, e.tone));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stateCode = 3'd0; standbyOpt = 1'b1; tickDiv = 16'd1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!greenLed && !redLed && !buzzer, "R6 reset outputs low",
          $sformatf("%0d%0d%0d", greenLed, redLed, buzzer), "000");
    rstN = 1'b1;

    // R1 standby option captured once
    enter(3'd0);
    expectAt(8, 1, 1, 0, "R1 standby lit");
    repeat (16) @(negedge clk);
    standbyOpt = 1'b0;
    expectAt(40, 1, 1, 0, "R1 option change ignored");
    waitRel(56);

    // R2 R7 R11 transfer with chime (tone toggles every 2 clocks)
    enter(3'd1);
    expectAt(8,   1, 0, 1, "R7 R11 chime sounding");
    expectAt(40,  0, 0, 0, "R2 R7 green off chime over");
    expectAt(72,  1, 0, 0, "R2 green on again");
    expectAt(104, 0, 0, 0, "R2 green off again");
    waitRel(120);

    // R3 complete
    enter(3'd2);
    expectAt(16, 1, 0, 0, "R3 complete");
    expectAt(60, 1, 0, 0, "R3 complete steady");
    waitRel(80);

    // R4 faults
    enter(3'd3);
    expectAt(8, 0, 1, 0, "R4 fault code3");
    waitRel(24);
    enter(3'd7);
    expectAt(8, 0, 1, 0, "R4 fault code7");
    waitRel(24);

    // R5 warning fast blink
    enter(3'd4);
    expectAt(6,  0, 1, 0, "R5 warn red on");
    expectAt(22, 0, 0, 0, "R5 warn red off");
    expectAt(38, 0, 1, 0, "R5 warn red on again");
    waitRel(56);

    // R8 R9 alarm cadence: burst 24 clk in 64, sections 192 sound / 128 quiet
    enter(3'd5);
    expectAt(8,   0, 1, 1, "R8 burst one");
    expectAt(40,  0, 0, 0, "R8 gap");
    expectAt(72,  0, 1, 1, "R8 burst two");
    expectAt(136, 0, 1, 1, "R8 burst three");
    expectAt(200, 0, 1, 0, "R9 quiet red lit");
    expectAt(232, 0, 0, 0, "R9 quiet gap");
    expectAt(264, 0, 1, 0, "R9 quiet red lit again");
    expectAt(328, 0, 1, 1, "R9 cycle repeats");
    waitRel(340);

    // R10 leave mid-burst, then re-enter
    enter(3'd2);
    expectAt(4, 1, 0, 0, "R10 silenced on leave");
    waitRel(16);
    enter(3'd5);
    expectAt(8,   0, 1, 1, "R10 restart at tone section");
    expectAt(200, 0, 1, 0, "R10 R9 quiet after restart");
    waitRel(216);

    // R1 second reset with option low
    @(negedge clk);
    rstN = 1'b0; stateCode = 3'd0; standbyOpt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    enter(3'd0);
    expectAt(8, 0, 0, 0, "R1 standby dark");
    repeat (16) @(negedge clk);
    standbyOpt = 1'b1;
    expectAt(40, 0, 0, 0, "R1 option rise ignored");
    waitRel(56);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule